// File: doc/BRIEF.md
# Half-Bridge Protection Supervisor

This block sits between a motor-control timer and a three-phase half-bridge gate driver. It receives the six requested gate commands (one high-side and one low-side per phase) and passes them on only when it is safe. Its safety inputs are an overcurrent comparator flag, a low-side supply undervoltage flag, one undervoltage flag per high-side bootstrap supply, and the sensed level of a shared, wired, active-low fault line. These inputs are asynchronous. Each passes through a two-flop synchronizer before any use.

The block treats faults differently by type. An overcurrent or a low-side undervoltage blanks every gate, pulls the fault line low and starts a hold-off timer. The line is released only after the timer has run out and both sources are quiet. A high-side undervoltage stops only its own phase and leaves the fault line alone. When another device pulls the shared line low, all gates are blanked, but the block does not latch the condition. After any blanking ends, a gate turns on again only on a fresh rising edge of its command. A small sticky register records which sources have tripped since it was last cleared.

Top module: `inv_fault_supervisor`

## Requirements
- R1: After reset, all gate enables are 0, `fault_drive_n` is 1 (line released) and `cause_status` is 0.
- R2: A command that rises while nothing blanks the phase drives its gate enable to 1 at the next clock edge, and the gate follows the command from then on. With all commands low, all enables are 0.
- R3: When the high and low commands of one phase are both 1, both enables of that phase are 0. The other phases are unaffected.
- R4: An overcurrent flag is visible at the ports at the third rising clock edge after it is asserted. From that edge, all six enables are 0 and `fault_drive_n` is 0.
- R5: Once tripped, `fault_drive_n` stays 0 for at least HOLD_CYCLES clock cycles. It returns to 1 at the first edge where the hold count has expired and neither overcurrent nor low-side undervoltage is present.
- R6: While low-side undervoltage persists, `fault_drive_n` stays 0 and all enables stay 0, even beyond the hold time. The line is released on the third edge after the flag clears, provided the hold time is over.
- R7: A high-side undervoltage on phase p forces both enables of phase p to 0 within three edges. Other phases are unaffected and `fault_drive_n` stays 1.
- R8: After any blanking ends, a gate whose command stayed high throughout the blanking remains 0. It turns on only after its command goes low and then high again.
- R9: When `fault_in_n` is held at 0, all enables go to 0 within three edges. This condition does not by itself drive `fault_drive_n` low.
- R10: `cause_status` holds bit 0 = overcurrent, bit 1 = low-side undervoltage, bit 2 = external disable. A bit sets one edge after its synchronized source is seen and stays set until `stat_clr` is 1 at a clock edge, which clears it at that edge unless the source is still active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oc_flag_a | input | 1 | Overcurrent comparator flag, asynchronous, active high |
| uv_low_a | input | 1 | Low-side supply undervoltage flag, asynchronous, active high |
| uv_high_a | input | NPH | Per-phase bootstrap supply undervoltage flags, asynchronous |
| fault_in_n | input | 1 | Sensed level of the shared fault line, asynchronous, low disables |
| cmd_hi | input | NPH | Requested high-side gate commands, active high |
| cmd_lo | input | NPH | Requested low-side gate commands, active high |
| stat_clr | input | 1 | Clear strobe for `cause_status` |
| gate_hi | output | NPH | Gated high-side enables |
| gate_lo | output | NPH | Gated low-side enables |
| fault_drive_n | output | 1 | Open-drain pull request for the fault line, 0 = pull low |
| cause_status | output | 3 | Sticky trip causes {external, low-side UV, overcurrent} |

## Verification
A wrong hold-timer state shows up on `fault_drive_n`: the line is released before HOLD_CYCLES has elapsed, or it sticks low after the sources are gone. The bench catches this within one cycle of the expected release edge. A stale re-arm bit shows up as a gate that comes back on right after a fault clears while its command is still held high, and this is visible on the first cycle after blanking ends. A missed synchronizer stage or an extra one shifts every trip by one edge. The bench samples the enables exactly at the second and third edges after a flag, so a shift in either direction is exposed.

// File: rtl/ifs_pkg.sv
// Shared types for the half-bridge protection supervisor.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package ifs_pkg;

    // Hold-off sequencer states.
    typedef enum logic [1:0] {
        HOLD_IDLE  = 2'd0,
        HOLD_COUNT = 2'd1,
        HOLD_WAIT  = 2'd2
    } hold_state_e;

    // Sticky trip cause record; bit order is visible at the top ports.
    typedef struct packed {
        logic ext_dis;
        logic uv_low;
        logic over_cur;
    } cause_t;

endpackage

// File: rtl/ifs_sync.sv
// Multi-stage synchronizer for a bus of independent asynchronous levels.
// Assumes: each bit is a slow level (no multi-bit coherency needed);
// RST_VAL gives the safe idle value of each bit.
module ifs_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stg [STAGES];

    // Shift the asynchronous levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d_async;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/ifs_hold_timer.sv
// Fault hold-off sequencer: enters hold when a latching source is busy,
// keeps the fault active for HOLD_CYCLES cycles from entry, then waits
// for all latching sources to clear before releasing.
// Assumes: src_busy is already synchronized.
module ifs_hold_timer
    import ifs_pkg::*;
#(
    parameter int HOLD_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_busy,
    output logic hold_active
);

    localparam int               CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD  = CNT_W'(HOLD_CYCLES - 1);

    hold_state_e       state;
    logic [CNT_W-1:0]  cnt;

    // Advance the hold-off state and its down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= HOLD_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                HOLD_IDLE: begin
                    if (src_busy) begin
                        state <= HOLD_COUNT;
                        cnt   <= LOAD;
                    end
                end
                HOLD_COUNT: begin
                    if (cnt != '0)     cnt   <= cnt - 1'b1;
                    else if (src_busy) state <= HOLD_WAIT;
                    else               state <= HOLD_IDLE;
                end
                HOLD_WAIT: begin
                    if (!src_busy) state <= HOLD_IDLE;
                end
                default: state <= HOLD_IDLE;
            endcase
        end
    end

    assign hold_active = (state != HOLD_IDLE);

endmodule

// File: rtl/ifs_phase_gate.sv
// One phase leg: blocks shoot-through, blanks both gates while blk is
// high, and re-arms each side only on a fresh rising command edge.
// Assumes: cmd_* are synchronous to clk; blk is synchronous.
module ifs_phase_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_h,
    input  logic cmd_l,
    input  logic blk,
    output logic en_h,
    output logic en_l
);

    logic cmd_h_q, cmd_l_q;
    logic arm_h, arm_l;
    logic rise_h, rise_l;

    assign rise_h = cmd_h & ~cmd_h_q;
    assign rise_l = cmd_l & ~cmd_l_q;

    // Remember previous command levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_h_q <= 1'b0;
            cmd_l_q <= 1'b0;
        end else begin
            cmd_h_q <= cmd_h;
            cmd_l_q <= cmd_l;
        end
    end

    // Arm on a rising command, disarm whenever the phase is blanked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_h <= 1'b0;
            arm_l <= 1'b0;
        end else if (blk) begin
            arm_h <= 1'b0;
            arm_l <= 1'b0;
        end else begin
            arm_h <= (arm_h | rise_h) & cmd_h;
            arm_l <= (arm_l | rise_l) & cmd_l;
        end
    end

    // Register the gated enables with shoot-through interlock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_h <= 1'b0;
            en_l <= 1'b0;
        end else begin
            en_h <= ~blk & cmd_h & ~cmd_l & (arm_h | rise_h);
            en_l <= ~blk & cmd_l & ~cmd_h & (arm_l | rise_l);
        end
    end

endmodule

// File: rtl/inv_fault_supervisor.sv
// Protection supervisor for a three-phase half-bridge driver.
// Synchronizes fault flags, latches overcurrent / low-side undervoltage
// into a timed hold-off that pulls the shared fault line, blanks phases
// on high-side undervoltage or external disable, and records trip causes.
// Assumes: commands are synchronous to clk; the fault line is wired-AND
// outside this block and fault_in_n is its sensed level.
module inv_fault_supervisor
    import ifs_pkg::*;
#(
    parameter int NPH         = 3,
    parameter int HOLD_CYCLES = 500000,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           oc_flag_a,
    input  logic           uv_low_a,
    input  logic [NPH-1:0] uv_high_a,
    input  logic           fault_in_n,
    input  logic [NPH-1:0] cmd_hi,
    input  logic [NPH-1:0] cmd_lo,
    input  logic           stat_clr,
    output logic [NPH-1:0] gate_hi,
    output logic [NPH-1:0] gate_lo,
    output logic           fault_drive_n,
    output logic [2:0]     cause_status
);

    localparam int            SW       = NPH + 3;
    localparam logic [SW-1:0] SYNC_RST = SW'(1) << (SW - 1);

    logic [SW-1:0]  raw_bus, syn_bus;
    logic           oc_s, uvl_s, ext_s;
    logic [NPH-1:0] uvh_s;
    logic           src_busy, hold_active, blk_all;
    cause_t         cause_q, cause_now;

    assign raw_bus = {fault_in_n, uv_high_a, uv_low_a, oc_flag_a};

    ifs_sync #(
        .W       (SW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_bus),
        .q_sync  (syn_bus)
    );

    assign oc_s  = syn_bus[0];
    assign uvl_s = syn_bus[1];
    assign uvh_s = syn_bus[NPH+1:2];
    assign ext_s = ~syn_bus[SW-1];

    assign src_busy = oc_s | uvl_s;

    ifs_hold_timer #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_busy    (src_busy),
        .hold_active (hold_active)
    );

    assign blk_all       = src_busy | hold_active | ext_s;
    assign fault_drive_n = ~hold_active;

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        ifs_phase_gate u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .cmd_h (cmd_hi[p]),
            .cmd_l (cmd_lo[p]),
            .blk   (blk_all | uvh_s[p]),
            .en_h  (gate_hi[p]),
            .en_l  (gate_lo[p])
        );
    end

    assign cause_now = '{ext_dis: ext_s, uv_low: uvl_s, over_cur: oc_s};

    // Sticky cause record: sources set bits, the strobe clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (stat_clr ? cause_t'('0) : cause_q) | cause_now;
    end

    assign cause_status = cause_q;

endmodule

// File: rtl/inv_fault_supervisor_chk.sv
// Port-level property checker for inv_fault_supervisor, bound below.
// Assumes: default synchronizer depth of two stages.
module inv_fault_supervisor_chk #(
    parameter int NPH         = 3,
    parameter int HOLD_CYCLES = 500000
) (
    input logic           clk,
    input logic           rst_n,
    input logic           oc_flag_a,
    input logic [NPH-1:0] uv_high_a,
    input logic           fault_in_n,
    input logic [NPH-1:0] gate_hi,
    input logic [NPH-1:0] gate_lo,
    input logic           fault_drive_n
);

    logic [31:0] low_run;

    // Count consecutive cycles the fault line has been pulled.
    always_ff @(posedge clk) begin
        if (!rst_n)              low_run <= '0;
        else if (fault_drive_n)  low_run <= '0;
        else if (low_run != '1)  low_run <= low_run + 1'b1;
    end

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == '0);                                   // R3

    AST_FAULT_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_drive_n |-> (gate_hi == '0 && gate_lo == '0));          // R4

    AST_OC_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
        oc_flag_a |-> ##3 !fault_drive_n);                            // R4

    AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_drive_n) |-> low_run >= 32'(HOLD_CYCLES));        // R5

    AST_EXT_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_in_n |-> ##3 (gate_hi == '0 && gate_lo == '0));         // R9

    for (genvar p = 0; p < NPH; p++) begin : g_uvh
        AST_UVH_PHASE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            uv_high_a[p] |-> ##3 (!gate_hi[p] && !gate_lo[p]));       // R7
    end

endmodule

bind inv_fault_supervisor inv_fault_supervisor_chk #(
    .NPH         (NPH),
    .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .oc_flag_a     (oc_flag_a),
    .uv_high_a     (uv_high_a),
    .fault_in_n    (fault_in_n),
    .gate_hi       (gate_hi),
    .gate_lo       (gate_lo),
    .fault_drive_n (fault_drive_n)
);

// File: tb/inv_fault_supervisor_test.sv
module inv_fault_supervisor_test;

    localparam int NPH  = 3;
    localparam int HOLD = 40;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           oc_flag_a, uv_low_a, fault_in_n, stat_clr;
    logic [NPH-1:0] uv_high_a, cmd_hi, cmd_lo;
    logic [NPH-1:0] gate_hi, gate_lo;
    logic           fault_drive_n;
    logic [2:0]     cause_status;

    always #2 clk = ~clk;

    inv_fault_supervisor #(.NPH(NPH), .HOLD_CYCLES(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .oc_flag_a(oc_flag_a), .uv_low_a(uv_low_a),
        .uv_high_a(uv_high_a), .fault_in_n(fault_in_n), .cmd_hi(cmd_hi),
        .cmd_lo(cmd_lo), .stat_clr(stat_clr), .gate_hi(gate_hi),
        .gate_lo(gate_lo), .fault_drive_n(fault_drive_n),
        .cause_status(cause_status)
    );

    typedef struct {
        logic [2:0] hi;
        logic [2:0] lo;
        logic       fn;
        logic [2:0] st;
        bit         use_st;
        string      req;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // Driver side: queue the expected port state for the monitor.
    task automatic expect_ports(input logic [2:0] hi, input logic [2:0] lo,
                                input logic fn, input logic [2:0] st,
                                input bit use_st, input string req);
        exp_t e;
        e.hi = hi; e.lo = lo; e.fn = fn; e.st = st; e.use_st = use_st; e.req = req;
        q.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Monitor: compare queued expectations just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (gate_hi !== e.hi || gate_lo !== e.lo || fault_drive_n !== e.fn ||
                    (e.use_st && cause_status !== e.st)) begin
                    n_fail++;
                    $display("FAIL %s: got hi=%b lo=%b fn=%b st=%b, expected hi=%b lo=%b fn=%b st=%b",
                             e.req, gate_hi, gate_lo, fault_drive_n, cause_status,
                             e.hi, e.lo, e.fn, e.st);
                end
            end
        end
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; oc_flag_a = 1'b0; uv_low_a = 1'b0; uv_high_a = '0;
        fault_in_n = 1'b1; stat_clr = 1'b0; cmd_hi = '0; cmd_lo = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        expect_ports(3'b000, 3'b000, 1'b1, 3'b000, 1, "R1");

        // R2: fresh commands pass after one edge
        cmd_hi = 3'b001; tick(1);
        expect_ports(3'b001, 3'b000, 1'b1, 3'b000, 1, "R2");
        cmd_lo = 3'b010; tick(1);
        expect_ports(3'b001, 3'b010, 1'b1, 3'b000, 1, "R2");

        // R3: both sides of phase 2 requested
        cmd_hi = 3'b101; cmd_lo = 3'b110; tick(1);
        expect_ports(3'b001, 3'b010, 1'b1, 3'b000, 1, "R3");
        cmd_hi = 3'b001; cmd_lo = 3'b010; tick(1);

        // R4/R5: overcurrent trip, hold, release
        oc_flag_a = 1'b1; tick(2);
        expect_ports(3'b001, 3'b010, 1'b1, 3'b000, 1, "R4 not before third edge");
        tick(1);
        expect_ports(3'b000, 3'b000, 1'b0, 3'b001, 1, "R4");
        tick(2);
        oc_flag_a = 1'b0;
        tick(HOLD - 4);
        expect_ports(3'b000, 3'b000, 1'b0, 3'b001, 1, "R5 held");
        tick(4);
        expect_ports(3'b000, 3'b000, 1'b1, 3'b001, 1, "R5 released, R8 no rearm");

        // R10: clear strobe
        stat_clr = 1'b1; tick(1); stat_clr = 1'b0;
        expect_ports(3'b000, 3'b000, 1'b1, 3'b000, 1, "R10");

        // R8: fresh edge re-arms
        cmd_hi = '0; cmd_lo = '0; tick(1);
        cmd_hi = 3'b001; cmd_lo = 3'b010; tick(1);
        expect_ports(3'b001, 3'b010, 1'b1, 3'b000, 1, "R8");

        // R7: high-side undervoltage on phase 1
        uv_high_a = 3'b010; tick(3);
        expect_ports(3'b001, 3'b000, 1'b1, 3'b000, 1, "R7");
        uv_high_a = '0; tick(4);
        expect_ports(3'b001, 3'b000, 1'b1, 3'b000, 1, "R7 R8 held level");
        cmd_lo = '0; tick(1);
        cmd_lo = 3'b010; tick(1);
        expect_ports(3'b001, 3'b010, 1'b1, 3'b000, 1, "R8 after R7");

        // R6: long low-side undervoltage
        uv_low_a = 1'b1; tick(3);
        expect_ports(3'b000, 3'b000, 1'b0, 3'b010, 1, "R6");
        tick(HOLD + 20);
        expect_ports(3'b000, 3'b000, 1'b0, 3'b010, 1, "R6 beyond hold");
        uv_low_a = 1'b0; tick(2);
        expect_ports(3'b000, 3'b000, 1'b0, 3'b010, 1, "R6 release timing");
        tick(2);
        expect_ports(3'b000, 3'b000, 1'b1, 3'b010, 1, "R6 released");
        stat_clr = 1'b1; tick(1); stat_clr = 1'b0;
        cmd_hi = '0; cmd_lo = '0; tick(1);
        cmd_hi = 3'b100; cmd_lo = 3'b001; tick(1);
        expect_ports(3'b100, 3'b001, 1'b1, 3'b000, 1, "R8 after R6");

        // R9: external disable on the shared line
        fault_in_n = 1'b0; tick(3);
        expect_ports(3'b000, 3'b000, 1'b1, 3'b100, 1, "R9");
        fault_in_n = 1'b1; tick(3);
        expect_ports(3'b000, 3'b000, 1'b1, 3'b100, 1, "R9 R8 held level");
        cmd_hi = '0; cmd_lo = '0; tick(1);
        expect_ports(3'b000, 3'b000, 1'b1, 3'b100, 1, "R2 idle");
        cmd_hi = 3'b010; tick(1);
        expect_ports(3'b010, 3'b000, 1'b1, 3'b100, 1, "R9 rearm");

        tick(2);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule